// File: doc/BRIEF.md
# Packed Word Permute and Extract Unit

This block moves data within a 64-bit operand made of four 16-bit words. A single operation select picks one of four functions: rearranging the words under an 8-bit immediate, writing a 16-bit scalar into one word position, copying one word out to a 32-bit scalar, or gathering the top bit of every byte into a compact mask. It has no arithmetic. It is meant to sit in the media datapath of a larger core, next to the packed ALUs, where a lane shuffle or a lane-to-scalar bridge would otherwise need several moves.

Every request is a single cycle wide and is marked by an input strobe. The result appears one clock later with its own strobe. A small output controller has two states, `ST_IDLE` and `ST_SHOW`. It moves to `ST_SHOW` on any clock where the input strobe is high (transitions IDLE→SHOW and SHOW→SHOW). It moves to `ST_IDLE` on any clock where the strobe is low (transitions SHOW→IDLE and IDLE→IDLE). In `ST_IDLE` both result buses are zero.

The operation code is 0 permute, 1 insert, 2 extract and 3 sign gather. An output that the chosen operation does not produce is forced to zero.

Top module: `pkwd_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `res_valid`, `res_vec` and `res_scalar` are all zero.
- R2: `res_valid` is high in the cycle after every cycle in which `req_valid` was high, and low otherwise.
- R3: With op 0 (permute), word i of `res_vec` (bits 16i+15:16i) equals source word number `req_imm[2i+1:2i]`, and `res_scalar` is zero.
- R4: With op 1 (insert), the word at index `req_imm[1:0]` of `res_vec` equals `req_scalar`, the other three words equal the source words, `req_imm[7:2]` has no effect, and `res_scalar` is zero.
- R5: With op 2 (extract), `res_scalar` equals the source word at index `req_imm[1:0]`, zero-extended to 32 bits. `req_imm[7:2]` has no effect, and `res_vec` is zero.
- R6: With op 3 (sign gather), `res_scalar` bit k equals source bit 8k+7 for k = 0..7, bits 31:8 are zero, and `res_vec` is zero.
- R7: In every cycle in which `res_valid` is low, `res_vec` and `res_scalar` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, one cycle per operation |
| req_op | input | 2 | Operation: 0 permute, 1 insert, 2 extract, 3 sign gather |
| req_vec | input | 64 | Source operand, four 16-bit words |
| req_scalar | input | 16 | Scalar written by insert |
| req_imm | input | 8 | Immediate: permute control, or word index in bits 1:0 |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_vec | output | 64 | Vector result (permute, insert) |
| res_scalar | output | 32 | Scalar result (extract, sign gather) |

## Verification
The only state is the result registers and the two-state output controller. A fault in either one shows up at the ports in the cycle right after the request that caused it. A wrong state shows as a strobe that comes early, comes late or stays high. A wrong register shows as a stale value that is not cleared in an idle cycle, or as a word in the wrong lane. The reference model compares all three outputs on every clock, so any such fault is caught in that same cycle. Directed cases include the identity permute, the reversed permute and both broadcast permutes. They also cover insert and extract with the upper immediate bits set, and sign masks with all bits set and with alternating bits.

// File: rtl/pkwd_pkg.sv
package pkwd_pkg;

    typedef enum logic [1:0] {
        OP_PERM = 2'd0,
        OP_INS  = 2'd1,
        OP_EXT  = 2'd2,
        OP_SGN  = 2'd3
    } pkwd_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } pkwd_st_e;

endpackage

// File: rtl/pkwd_perm.sv
module pkwd_perm #(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic [LANES*IDX_W-1:0]  ctrl,
    input  logic [LANES*LANE_W-1:0] src,
    output logic [LANES*LANE_W-1:0] dst
);
    // Each destination lane has its own source selector.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [IDX_W-1:0] sel;
        assign sel = ctrl[i*IDX_W +: IDX_W];
        assign dst[i*LANE_W +: LANE_W] = src[sel*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pkwd_insert.sv
module pkwd_insert #(
    parameter int LANES  = 4,
    parameter int LANE_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANE_W-1:0]       scalar,
    input  logic [LANES*LANE_W-1:0] src,
    output logic [LANES*LANE_W-1:0] dst
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dst[i*LANE_W +: LANE_W] =
            (idx == IDX_W'(i)) ? scalar : src[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pkwd_extract.sv
module pkwd_extract #(
    parameter int LANES    = 4,
    parameter int LANE_W   = 16,
    parameter int IDX_W    = 2,
    parameter int SCALAR_W = 32
) (
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANES*LANE_W-1:0] src,
    output logic [SCALAR_W-1:0]     scalar
);
    localparam int PAD_W = SCALAR_W - LANE_W;

    logic [LANE_W-1:0] word;
    assign word   = src[idx*LANE_W +: LANE_W];
    assign scalar = {{PAD_W{1'b0}}, word};
endmodule

// File: rtl/pkwd_signmask.sv
module pkwd_signmask #(
    parameter int VEC_W    = 64,
    parameter int SCALAR_W = 32
) (
    input  logic [VEC_W-1:0]    src,
    output logic [SCALAR_W-1:0] mask
);
    localparam int BYTES = VEC_W / 8;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        assign mask[k] = src[8*k + 7];
    end
    assign mask[SCALAR_W-1:BYTES] = '0;
endmodule

// File: rtl/pkwd_unit.sv
module pkwd_unit
    import pkwd_pkg::*;
#(
    parameter  int LANES    = 4,
    parameter  int LANE_W   = 16,
    parameter  int SCALAR_W = 32,
    localparam int VEC_W    = LANES * LANE_W,
    localparam int IDX_W    = $clog2(LANES),
    localparam int IMM_W    = LANES * IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [VEC_W-1:0]    req_vec,
    input  logic [LANE_W-1:0]   req_scalar,
    input  logic [IMM_W-1:0]    req_imm,
    output logic                res_valid,
    output logic [VEC_W-1:0]    res_vec,
    output logic [SCALAR_W-1:0] res_scalar
);
    pkwd_op_e          op;
    pkwd_st_e          state, state_nxt;
    logic [VEC_W-1:0]    perm_vec, ins_vec, nxt_vec, vec_q;
    logic [SCALAR_W-1:0] ext_sc, sgn_sc, nxt_sc, sc_q;

    assign op = pkwd_op_e'(req_op);

    pkwd_perm #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_perm (
        .ctrl (req_imm),
        .src  (req_vec),
        .dst  (perm_vec)
    );

    pkwd_insert #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_ins (
        .idx    (req_imm[IDX_W-1:0]),
        .scalar (req_scalar),
        .src    (req_vec),
        .dst    (ins_vec)
    );

    pkwd_extract #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W),
                   .SCALAR_W(SCALAR_W)) u_ext (
        .idx    (req_imm[IDX_W-1:0]),
        .src    (req_vec),
        .scalar (ext_sc)
    );

    pkwd_signmask #(.VEC_W(VEC_W), .SCALAR_W(SCALAR_W)) u_sgn (
        .src  (req_vec),
        .mask (sgn_sc)
    );

    // Route the selected operation's results; zero the unused bus.
    always_comb begin
        nxt_vec = '0;
        nxt_sc  = '0;
        unique case (op)
            OP_PERM: nxt_vec = perm_vec;
            OP_INS:  nxt_vec = ins_vec;
            OP_EXT:  nxt_sc  = ext_sc;
            OP_SGN:  nxt_sc  = sgn_sc;
            default: ;
        endcase
    end

    // Next-state logic for the output controller.
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = req_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nxt = req_valid ? ST_SHOW : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Result registers, cleared on cycles without a request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            vec_q <= '0;
            sc_q  <= '0;
        end else begin
            vec_q <= nxt_vec;
            sc_q  <= nxt_sc;
        end
    end

    assign res_valid  = (state == ST_SHOW);
    assign res_vec    = vec_q;
    assign res_scalar = sc_q;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                              // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);                                            // R2
    AST_PERM_NO_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_op) == 2'd0) |-> res_scalar == '0);            // R3
    AST_INS_NO_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_op) == 2'd1) |-> res_scalar == '0);            // R4
    AST_EXT_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_op) == 2'd2)
            |-> (res_scalar[SCALAR_W-1:LANE_W] == '0 && res_vec == '0));       // R5
    AST_SGN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(req_op) == 2'd3)
            |-> (res_scalar[SCALAR_W-1:VEC_W/8] == '0 && res_vec == '0));      // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_vec == '0 && res_scalar == '0));                   // R7
endmodule

// File: tb/sim_pkwd_unit.sv
module sim_pkwd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [63:0] req_vec = '0;
    logic [15:0] req_scalar = '0;
    logic [7:0]  req_imm = '0;
    logic        res_valid;
    logic [63:0] res_vec;
    logic [31:0] res_scalar;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic        v;
        logic [2:0]  tag;   // 0..3 op, 4 idle, 5 reset
        logic [63:0] vec;
        logic [31:0] sc;
    } exp_t;

    exp_t expq[$];

    always #4 clk = ~clk;

    pkwd_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_vec(req_vec), .req_scalar(req_scalar), .req_imm(req_imm),
        .res_valid(res_valid), .res_vec(res_vec), .res_scalar(res_scalar)
    );

    function automatic string tagname(input logic [2:0] t);
        case (t)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R1";
        endcase
    endfunction

    function automatic exp_t model(input bit v, input int op, input logic [63:0] vec,
                                   input logic [15:0] sc, input logic [7:0] imm);
        exp_t e;
        int   idx;
        e = '0;
        e.v = v;
        e.tag = v ? 3'(op) : 3'd4;
        if (!v) return e;
        idx = imm % 4;
        case (op)
            0: for (int i = 0; i < 4; i++) begin
                   int s;
                   s = (imm >> (2*i)) % 4;
                   e.vec = e.vec | (((vec >> (16*s)) & 64'hFFFF) << (16*i));
               end
            1: e.vec = (vec & ~(64'hFFFF << (16*idx))) | (64'(sc) << (16*idx));
            2: e.sc = 32'((vec >> (16*idx)) & 64'hFFFF);
            default: for (int k = 0; k < 8; k++)
                         if (vec[8*k+7]) e.sc = e.sc + (32'd1 << k);
        endcase
        return e;
    endfunction

    task automatic compare();
        exp_t e;
        e = expq.pop_front();
        n_chk += 3;
        if (res_valid !== e.v) begin
            n_bad++;
            $display("FAIL %s valid: got %0b exp %0b", (e.tag == 3'd5) ? "R1" : "R2",
                     res_valid, e.v);
        end
        if (res_vec !== e.vec) begin
            n_bad++;
            $display("FAIL %s vec: got %h exp %h", tagname(e.tag), res_vec, e.vec);
        end
        if (res_scalar !== e.sc) begin
            n_bad++;
            $display("FAIL %s scalar: got %h exp %h", tagname(e.tag), res_scalar, e.sc);
        end
    endtask

    task automatic step(input bit v, input int op, input logic [63:0] vec,
                        input logic [15:0] sc, input logic [7:0] imm);
        @(negedge clk);
        compare();
        req_valid  = v;
        req_op     = 2'(op);
        req_vec    = vec;
        req_scalar = sc;
        req_imm    = imm;
        expq.push_back(model(v, op, vec, sc, imm));
    endtask

    localparam logic [63:0] V0 = 64'h4444_3333_2222_1111;

    initial begin
        exp_t r;
        r = '0;
        r.tag = 3'd5;
        // R1: reset state observed during and just after reset
        expq.push_back(r);
        expq.push_back(r);
        @(negedge clk); compare();
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0);                       // R1 after release
        // R3: identity, reverse, broadcast
        step(1, 0, V0, 16'h0, 8'hE4);
        step(1, 0, V0, 16'h0, 8'h1B);
        step(1, 0, V0, 16'h0, 8'h00);
        step(1, 0, V0, 16'h0, 8'hFF);
        // R4: insert at each lane, upper imm bits set
        for (int i = 0; i < 4; i++) step(1, 1, V0, 16'hBEEF, 8'hFC | 8'(i));
        // R5: extract each lane with upper imm bits set
        for (int i = 0; i < 4; i++) step(1, 2, 64'hF00D_8001_7FFF_ABCD, 16'h1234, 8'hA8 | 8'(i));
        // R6: sign masks
        step(1, 3, 64'h8080_8080_8080_8080, 0, 8'h55);
        step(1, 3, 64'h80_7F_80_7F_80_7F_80_7F, 0, 0);
        step(1, 3, 64'h7F7F_7F7F_7F7F_7F7F, 0, 0);
        // R7, R2: gap then back-to-back
        step(0, 1, V0, 16'hFFFF, 8'h01);
        step(0, 2, V0, 16'hFFFF, 8'h03);
        for (int n = 0; n < 400; n++) begin
            step(($urandom % 4) != 0, int'($urandom % 4),
                 {$urandom, $urandom}, 16'($urandom), 8'($urandom));
        end
        step(0, 0, 0, 0, 0);
        @(negedge clk); compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule